// File: doc/BRIEF.md
# Serial Byte Receiver for a Display Controller

This block is the write-only serial host port of a display controller. A host drives a serial clock, a serial data line, a data/command select and an active-low select. The block samples all four lines into the system clock domain and finds the rising edges of the serial clock there. It shifts one data bit in on each of those edges and assembles whole bytes.

When the last bit of a byte arrives, the same serial clock edge also samples the data/command select. That sampled value decides where the finished byte goes. The block then raises a single-cycle strobe on either the display-RAM write port or the command write port, and presents the byte on a shared data output.

Raising the select at any time abandons a partly received byte and returns the bit counter to the start. While the select stays low, bytes may follow one another with no gap.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, both write strobes are low and the byte output is all zeros.
- R2: Data bits enter most significant first. The first bit after selection, or after the previous byte, becomes bit 7 of the output byte, and the eighth bit becomes bit 0.
- R3: The data/command line is sampled only at the eighth rising serial clock edge of a byte. A value of 1 there sends the byte to the RAM strobe, and a value of 0 sends it to the command strobe. Its level at earlier edges of the byte has no effect.
- R4: Each completed byte produces exactly one strobe pulse. That pulse lasts one system clock cycle, and the RAM and command strobes are never high together.
- R5: A high level on the select clears the bit counter and discards any partial byte, so no strobe results from it. The next byte starts again at bit 7.
- R6: After the eighth bit, the counter wraps to zero, so consecutive bytes need no idle time while the select stays low.
- R7: Serial clock edges that occur while the select is high shift no data and advance no count.
- R8: The byte output changes only in a cycle in which one of the strobes is high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sda_i | input | 1 | Serial data from the host, asynchronous |
| dc_i | input | 1 | Data (1) or command (0) select, asynchronous |
| cs_n_i | input | 1 | Active-low select, asynchronous |
| wr_data_o | output | 8 | Last completed byte |
| ram_we_o | output | 1 | One-cycle display-RAM write strobe |
| cmd_we_o | output | 1 | One-cycle command write strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and two synchronizer stages. This makes the three-clock path from a pin edge to a strobe, and the wrap of the 3-bit counter from 7 back to 0, reachable with short serial clock phases. The host stimulus holds each serial clock phase for four system clocks, so every edge is seen exactly once. The stimulus covers a data/command line that toggles inside a byte, a select raised after five bits, serial clocks given while deselected, a reset in mid-byte, and two bytes sent back to back.

// File: rtl/serial_rx_pkg.sv
// Package: shared constants and types for the serial byte receiver.
// Assumes: the byte width is at least 2 bits.
package serial_rx_pkg;

    // Index of each line inside the synchronized pin vector
    localparam int unsigned PIN_SCK  = 0;
    localparam int unsigned PIN_SDA  = 1;
    localparam int unsigned PIN_DC   = 2;
    localparam int unsigned PIN_CSN  = 3;
    localparam int unsigned PIN_CNT  = 4;

    // Destination of a completed byte
    typedef enum logic {
        DEST_CMD = 1'b0,
        DEST_RAM = 1'b1
    } dest_e;

endpackage

// File: rtl/srx_sync.sv
// Module: srx_sync
// Purpose: multi-stage synchronizer for a vector of independent
// asynchronous single-bit lines.
// Assumes: each bit is treated on its own, with no coherence between bits;
// on reset every stage loads RST_VAL.
module srx_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // First stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= async_i;
    end

    // Remaining stages form a chain of plain flops
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/srx_edge.sv
// Module: srx_edge
// Purpose: finds rising edges of the synchronized serial clock and lets
// them through only while the select is active.
// Assumes: inputs are already synchronous to clk.
module srx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic csn_s,
    output logic rise_o
);

    logic sck_q;

    // Remember the previous serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Qualified rising edge
    always_comb begin
        rise_o = sck_s && !sck_q && !csn_s;
    end

    // R4: edges never arrive in two cycles in a row
    a_r4_rise_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/srx_shifter.sv
// Module: srx_shifter
// Purpose: bit counter and shift register; flags the edge that completes
// a byte and presents the byte including that final bit.
// Assumes: rise_i is a single-cycle pulse already gated by the select.
module srx_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              sda_s,
    input  logic              csn_s,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shift_q;

    // Count bits; clear on deselect; wrap after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s)  cnt_q <= '0;
        else if (rise_i)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Shift the data bit in at the low end; drop partial bytes on deselect
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s) shift_q <= '0;
        else if (rise_i)     shift_q <= {shift_q[BYTE_W-2:0], sda_s};
    end

    // Completion flag and the full byte seen at the final edge
    always_comb begin
        done_o = rise_i && (cnt_q == LAST);
        byte_o = {shift_q[BYTE_W-2:0], sda_s};
    end

    // R5: a deselect leaves the counter at zero
    a_r5_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (cnt_q == '0));

    // R6: the counter wraps after the last bit
    a_r6_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !csn_s && cnt_q == LAST) |=> (cnt_q == '0));

    // R7: without an edge the counter holds, unless deselected
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !csn_s) |=> $stable(cnt_q));

endmodule

// File: rtl/srx_router.sv
// Module: srx_router
// Purpose: registers the finished byte and raises the strobe of the
// destination chosen by the data/command level seen at the final edge.
// Assumes: done_i is a single-cycle pulse.
module srx_router
    import serial_rx_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              dc_s,
    output logic [BYTE_W-1:0] data_o,
    output logic              ram_we_o,
    output logic              cmd_we_o
);

    dest_e dest;

    // Decode the sampled select level into a destination
    always_comb begin
        dest = dc_s ? DEST_RAM : DEST_CMD;
    end

    // Capture the byte at completion only
    always_ff @(posedge clk) begin
        if (!rst_n)      data_o <= '0;
        else if (done_i) data_o <= byte_i;
    end

    // One-cycle strobes to the chosen port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_o <= 1'b0;
            cmd_we_o <= 1'b0;
        end else begin
            ram_we_o <= done_i && (dest == DEST_RAM);
            cmd_we_o <= done_i && (dest == DEST_CMD);
        end
    end

    // R4: never both strobes
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we_o && cmd_we_o));

    // R4: each strobe lasts one cycle
    a_r4_ram_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |=> !ram_we_o);
    a_r4_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_o |=> !cmd_we_o);

    // R3: a RAM strobe follows a completion seen with the select high
    a_r3_ram_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && dc_s) |=> ram_we_o);

    // R8: the byte output moves only together with a strobe
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> (ram_we_o || cmd_we_o));

endmodule

// File: rtl/serial_byte_rx.sv
// Module: serial_byte_rx (top)
// Purpose: write-only serial host receiver. It synchronizes the four host
// lines, assembles bytes most significant bit first, and strobes the RAM
// port or the command port once for each completed byte.
// Assumes: each serial clock phase lasts longer than SYNC_STAGES+1 system
// clocks, and data and select are stable around each rising serial edge.
module serial_byte_rx
    import serial_rx_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sda_i,
    input  logic              dc_i,
    input  logic              cs_n_i,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              ram_we_o,
    output logic              cmd_we_o
);

    localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_CSN;

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_s;
    logic               rise;
    logic               done;
    logic [BYTE_W-1:0]  byte_w;

    // Gather the raw pins into one vector
    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_SCK] = sck_i;
        pins_raw[PIN_SDA] = sda_i;
        pins_raw[PIN_DC]  = dc_i;
        pins_raw[PIN_CSN] = cs_n_i;
    end

    srx_sync #(
        .WIDTH   (PIN_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    srx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (pins_s[PIN_SCK]),
        .csn_s  (pins_s[PIN_CSN]),
        .rise_o (rise)
    );

    srx_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .sda_s  (pins_s[PIN_SDA]),
        .csn_s  (pins_s[PIN_CSN]),
        .done_o (done),
        .byte_o (byte_w)
    );

    srx_router #(
        .BYTE_W (BYTE_W)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done),
        .byte_i   (byte_w),
        .dc_s     (pins_s[PIN_DC]),
        .data_o   (wr_data_o),
        .ram_we_o (ram_we_o),
        .cmd_we_o (cmd_we_o)
    );

    // R1: outputs are at rest in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!ram_we_o && !cmd_we_o && wr_data_o == '0));

endmodule

// File: tb/tb_serial_byte_rx.sv
module tb_serial_byte_rx;

    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 4;
    localparam int NVEC       = 6;
    // Each entry: {dc, byte}; the expected strobe is dc, the expected data is byte
    localparam logic [8:0] VEC [NVEC] = '{9'h1A5, 9'h03C, 9'h1FF, 9'h000, 9'h181, 9'h07E};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sda = 1'b0, dc = 1'b0, cs_n = 1'b1;
    logic [7:0] wr_data;
    logic       ram_we, cmd_we;

    int n_chk = 0, n_fail = 0;
    int n_ram = 0, n_cmd = 0, hi_run = 0, long_pulse = 0, both_hi = 0, data_moves = 0;
    logic [7:0] last_b = '0, prev_b = '0, data_prev = '0;
    logic       last_dc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_byte_rx dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sda_i(sda), .dc_i(dc),
        .cs_n_i(cs_n), .wr_data_o(wr_data), .ram_we_o(ram_we), .cmd_we_o(cmd_we)
    );

    // Monitor sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we && cmd_we) both_hi++;
            if (ram_we || cmd_we) begin
                hi_run++;
                if (hi_run > 1) long_pulse++;
                prev_b  = last_b;
                last_b  = wr_data;
                last_dc = ram_we;
                if (ram_we) n_ram++;
                if (cmd_we) n_cmd++;
            end else begin
                hi_run = 0;
                if (wr_data != data_prev) data_moves++;
            end
            data_prev = wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic d);
        @(negedge clk);
        sda = b; dc = d;
        wait_clk(PHASE);
        sck = 1'b1;
        wait_clk(PHASE);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic d, input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i], d);
    endtask

    task automatic finish_run;
        chk(both_hi == 0, "R4 strobes together", both_hi, 0);
        chk(long_pulse == 0, "R4 pulse width", long_pulse, 0);
        chk(data_moves == 0, "R8 data moved without strobe", data_moves, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int r0, c0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset state
        chk(!ram_we && !cmd_we, "R1 strobes", {ram_we, cmd_we}, 0);
        chk(wr_data == 8'h00, "R1 data", wr_data, 0);

        cs_n = 1'b0;
        wait_clk(4);
        // R2 R3 R4: vector table
        for (int v = 0; v < NVEC; v++) begin
            r0 = n_ram; c0 = n_cmd;
            send_byte(VEC[v][8], VEC[v][7:0]);
            wait_clk(6);
            chk(last_b == VEC[v][7:0], "R2 byte value", last_b, VEC[v][7:0]);
            chk(last_dc == VEC[v][8], "R3 destination", last_dc, VEC[v][8]);
            chk((n_ram - r0) + (n_cmd - c0) == 1, "R4 one strobe per byte",
                (n_ram - r0) + (n_cmd - c0), 1);
        end

        // R3: select high for seven bits, low at the eighth gives a command
        r0 = n_ram; c0 = n_cmd;
        for (int i = 7; i >= 1; i--) send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        wait_clk(6);
        chk(n_cmd - c0 == 1 && n_ram == r0, "R3 late dc low", n_cmd - c0, 1);
        chk(last_b == 8'hFE, "R3 byte", last_b, 8'hFE);
        // R3: reverse case gives a RAM write
        r0 = n_ram;
        for (int i = 7; i >= 1; i--) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);
        wait_clk(6);
        chk(n_ram - r0 == 1, "R3 late dc high", n_ram - r0, 1);
        chk(last_b == 8'h01, "R3 byte", last_b, 8'h01);

        // R5: five bits, deselect, then a full byte
        r0 = n_ram; c0 = n_cmd;
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
        wait_clk(2);
        cs_n = 1'b1;
        wait_clk(6);
        chk(n_ram == r0 && n_cmd == c0, "R5 partial dropped", n_ram - r0, 0);
        cs_n = 1'b0;
        wait_clk(4);
        send_byte(1'b1, 8'h5A);
        wait_clk(6);
        chk(n_ram - r0 == 1 && last_b == 8'h5A, "R5 restart at bit 7", last_b, 8'h5A);

        // R7: clocks while deselected are ignored
        cs_n = 1'b1;
        wait_clk(4);
        r0 = n_ram; c0 = n_cmd;
        send_byte(1'b1, 8'hC3);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        wait_clk(6);
        chk(n_ram == r0 && n_cmd == c0, "R7 no strobe deselected", n_ram - r0, 0);
        cs_n = 1'b0;
        wait_clk(4);
        send_byte(1'b0, 8'h96);
        wait_clk(6);
        chk(n_cmd - c0 == 1 && last_b == 8'h96, "R7 count not advanced", last_b, 8'h96);

        // R6: two bytes back to back with no gap
        r0 = n_ram; c0 = n_cmd;
        send_byte(1'b1, 8'h3D);
        send_byte(1'b0, 8'hE4);
        wait_clk(6);
        chk(n_ram - r0 == 1 && n_cmd - c0 == 1, "R6 two strobes",
            (n_ram - r0) + (n_cmd - c0), 2);
        chk(prev_b == 8'h3D, "R6 first byte", prev_b, 8'h3D);
        chk(last_b == 8'hE4, "R6 second byte", last_b, 8'hE4);

        // R1: reset in mid-byte, then a clean byte
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(3);
        chk(wr_data == 8'h00 && !ram_we && !cmd_we, "R1 reset mid-byte", wr_data, 0);
        data_prev = 8'h00;
        rst_n = 1'b1;
        wait_clk(4);
        r0 = n_ram;
        send_byte(1'b1, 8'h27);
        wait_clk(6);
        chk(n_ram - r0 == 1 && last_b == 8'h27, "R1 byte after reset", last_b, 8'h27);

        finish_run();
    end

endmodule